// File: doc/BRIEF.md
# Multi-Lane Transposed FIR Filter

This block filters a single sampled stream whose sample rate is several times the logic clock. On every clock a word of `LANES` consecutive samples arrives, and the block returns a word of `LANES` filtered samples, one per input sample. The output rate equals the input rate, so nothing is decimated or interpolated.

Each input sample is multiplied by every coefficient in the same cycle. The products are gathered by their distance in time from the start of the current word. Sums that land inside the current word become outputs. Sums that land in later words are held in carry registers until those words arrive. This is the transposed structure unrolled across the lanes. There is one register after each summation, which keeps the adder depth from growing with the tap count.

The coefficients are fixed at elaboration through a packed parameter, with tap `i` in bits `[i*CW +: CW]`. Words are accepted only while `in_valid` is high, and a synchronous reset clears all history.

Top module: `fir_par_transposed`

## Requirements
- R1: A word presented with `in_valid` high at a rising edge appears on `out_data` one clock later, with `out_valid` high in that same cycle.
- R2: In the input and output words, lane j sits at bits `[j*W +: W]`, and lane 0 holds the oldest sample. Output lane j of a word equals the sum over taps i of `w_i * x(n-i)`, where n is the stream index of input lane j. All values are signed two's complement.
- R3: Terms that reach back before lane 0 of the current word are taken from earlier accepted words. This holds even when the tap count exceeds `LANES+1`, so that history spans more than one word.
- R4: Outputs are full precision, with width `OW = DW + CW + ceil(log2(TAPS))`. Extreme inputs and coefficients produce exact results with no wrap.
- R5: A cycle with `in_valid` low leaves the filter history untouched and holds `out_data`. In the following cycle `out_valid` is low. The stream continues across the gap as if the gap were absent.
- R6: While `rst` is high at a rising edge, `out_valid` and `out_data` clear and all carried sums clear, even if `in_valid` is high. After reset, samples before the first accepted word count as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The input word is accepted at this edge |
| in_data | input | LANES*DW | Input samples, lane 0 oldest |
| out_valid | output | 1 | `out_data` holds a new word |
| out_data | output | LANES*OW | Filtered samples, lane 0 oldest |

## Verification
Every result is due exactly one rising edge after the word that produced it. The bench drives a word on a falling edge, waits for the next rising edge, and compares all lanes of both filter instances on the falling edge after that. An idle cycle is checked in the same slot: it must show `out_valid` low and the previous word unchanged. A reset is checked one edge after it is applied, and the words that follow then confirm that no old history leaks through.

// File: rtl/fir_par_pkg.sv
`timescale 1ns/1ps
package fir_par_pkg;

    // full-precision output width for a given sample, coefficient and tap count
    function automatic int out_width(int dw, int cw, int taps);
        return dw + cw + ((taps > 1) ? $clog2(taps) : 0);
    endfunction

    // number of partial sums carried into later words
    function automatic int carry_len(int taps);
        return (taps > 1) ? taps - 1 : 1;
    endfunction

    // number of time offsets one word's products can reach
    function automatic int span(int lanes, int taps);
        return lanes + taps - 1;
    endfunction

    // true when input lane (offs - tap) exists inside one word
    function automatic bit lane_hit(int offs, int tap, int lanes);
        return (offs - tap >= 0) && (offs - tap < lanes);
    endfunction

endpackage

// File: rtl/fir_par_lane_mul.sv
`timescale 1ns/1ps
// One input lane multiplied by every coefficient in parallel.
module fir_par_lane_mul #(
    parameter int TAPS = 4,
    parameter int DW   = 16,
    parameter int CW   = 16,
    localparam int PW  = DW + CW
) (
    input  logic signed [DW-1:0]   x,
    input  logic signed [CW-1:0]   ws [TAPS],
    output logic [TAPS*PW-1:0]     prod
);
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        logic signed [PW-1:0] p_i;
        assign p_i = x * ws[i];
        assign prod[i*PW +: PW] = p_i;
    end
endmodule

// File: rtl/fir_par_carry.sv
`timescale 1ns/1ps
// Partial sums that belong to later words.
module fir_par_carry #(
    parameter int CL = 3,
    parameter int OW = 34
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [OW-1:0] nxt [CL],
    output logic signed [OW-1:0] q   [CL]
);
    for (genvar m = 0; m < CL; m++) begin : g_cr
        always_ff @(posedge clk) begin
            if (rst)
                q[m] <= '0;
            else if (en)
                q[m] <= nxt[m];
        end
    end
endmodule

// File: rtl/fir_par_out_reg.sv
`timescale 1ns/1ps
// Output word register and the valid delay.
module fir_par_out_reg #(
    parameter int LANES = 4,
    parameter int OW    = 34
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic signed [OW-1:0]   y [LANES],
    output logic                   valid_q,
    output logic [LANES*OW-1:0]    data_q
);
    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else
            valid_q <= en;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                data_q[j*OW +: OW] <= '0;
            else if (en)
                data_q[j*OW +: OW] <= y[j];
        end
    end
endmodule

// File: rtl/fir_par_transposed.sv
`timescale 1ns/1ps
module fir_par_transposed
    import fir_par_pkg::*;
#(
    parameter int LANES = 4,
    parameter int TAPS  = 4,
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter logic [TAPS*CW-1:0] COEFS = {16'h0002, 16'h0010, 16'hFFF8, 16'h0004},
    localparam int OW   = out_width(DW, CW, TAPS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [LANES*DW-1:0]   in_data,
    output logic                  out_valid,
    output logic [LANES*OW-1:0]   out_data
);
    localparam int CL = carry_len(TAPS);
    localparam int SP = span(LANES, TAPS);
    localparam int PW = DW + CW;

    logic signed [DW-1:0] xs [LANES];
    logic signed [CW-1:0] ws [TAPS];
    logic [TAPS*PW-1:0]   prodv [LANES];
    logic signed [OW-1:0] acc [SP];
    logic signed [OW-1:0] carry_q   [CL];
    logic signed [OW-1:0] carry_nxt [CL];
    logic signed [OW-1:0] y [LANES];
    logic [CL*OW-1:0]     carry_flat;

    // unpack operands
    for (genvar i = 0; i < TAPS; i++) begin : g_coef
        assign ws[i] = COEFS[i*CW +: CW];
    end

    // every lane times every tap
    for (genvar p = 0; p < LANES; p++) begin : g_lane
        assign xs[p] = in_data[p*DW +: DW];
        fir_par_lane_mul #(.TAPS(TAPS), .DW(DW), .CW(CW)) u_mul (
            .x   (xs[p]),
            .ws  (ws),
            .prod(prodv[p])
        );
    end

    // gather products by time offset from lane 0 of this word
    for (genvar o = 0; o < SP; o++) begin : g_offs
        logic signed [OW-1:0] term [TAPS];
        for (genvar i = 0; i < TAPS; i++) begin : g_term
            if (lane_hit(o, i, LANES)) begin : g_on
                assign term[i] = OW'($signed(prodv[o-i][i*PW +: PW]));
            end else begin : g_off
                assign term[i] = '0;
            end
        end
        always_comb begin
            acc[o] = '0;
            for (int i = 0; i < TAPS; i++)
                acc[o] = acc[o] + term[i];
        end
    end

    // carry chain: offsets beyond this word shift down by LANES
    for (genvar m = 0; m < CL; m++) begin : g_cnxt
        if (TAPS < 2) begin : g_none
            assign carry_nxt[m] = '0;
        end else if (LANES + m < CL) begin : g_chain
            assign carry_nxt[m] = acc[LANES+m] + carry_q[LANES+m];
        end else begin : g_last
            assign carry_nxt[m] = acc[LANES+m];
        end
        assign carry_flat[m*OW +: OW] = carry_q[m];
    end

    fir_par_carry #(.CL(CL), .OW(OW)) u_carry (
        .clk(clk),
        .rst(rst),
        .en (in_valid),
        .nxt(carry_nxt),
        .q  (carry_q)
    );

    // output lanes: this word's sums plus the history carried in
    for (genvar j = 0; j < LANES; j++) begin : g_y
        if (TAPS > 1 && j < CL) begin : g_add
            assign y[j] = acc[j] + carry_q[j];
        end else begin : g_pass
            assign y[j] = acc[j];
        end
    end

    fir_par_out_reg #(.LANES(LANES), .OW(OW)) u_out (
        .clk    (clk),
        .rst    (rst),
        .en     (in_valid),
        .y      (y),
        .valid_q(out_valid),
        .data_q (out_data)
    );
endmodule

// File: rtl/fir_par_chk.sv
`timescale 1ns/1ps
module fir_par_chk #(
    parameter int LANES = 4,
    parameter int DW    = 16,
    parameter int OW    = 34,
    parameter int CL    = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [LANES*DW-1:0] in_data,
    input logic                out_valid,
    input logic [LANES*OW-1:0] out_data,
    input logic [CL*OW-1:0]    carry_flat
);
    a_r6_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0 && carry_flat == '0));

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(carry_flat)));

    a_r2_zero_word: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data == '0 && carry_flat == '0) |=> out_data == '0);

    a_r3_quiet_history: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_data == '0 && carry_flat == '0) |=> carry_flat == '0);
endmodule

bind fir_par_transposed fir_par_chk #(
    .LANES(LANES), .DW(DW), .OW(OW), .CL(CL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .carry_flat(carry_flat)
);

// File: tb/fir_par_transposed_tb.sv
`timescale 1ns/1ps
module fir_par_transposed_tb;
    localparam int LANES = 4;
    localparam int DW    = 12;
    localparam int CW    = 10;
    localparam int OW4   = fir_par_pkg::out_width(DW, CW, 4);
    localparam int OW7   = fir_par_pkg::out_width(DW, CW, 7);
    localparam logic [4*CW-1:0] K4 = {10'h002, 10'h007, 10'h3FB, 10'h003};
    localparam logic [7*CW-1:0] K7 = {10'h1FF, 10'h338, 10'h02D, 10'h000,
                                      10'h3FD, 10'h064, 10'h200};

    int c4 [4] = '{3, -5, 7, 2};
    int c7 [7] = '{-512, 100, -3, 0, 45, -200, 511};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [LANES*DW-1:0] in_data = '0;
    logic out_valid4, out_valid7;
    logic [LANES*OW4-1:0] out4;
    logic [LANES*OW7-1:0] out7;

    always #2.5 clk = ~clk;

    fir_par_transposed #(.LANES(LANES), .TAPS(4), .DW(DW), .CW(CW), .COEFS(K4)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid4), .out_data(out4));

    fir_par_transposed #(.LANES(LANES), .TAPS(7), .DW(DW), .CW(CW), .COEFS(K7)) u_dut_t7 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid7), .out_data(out7));

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int smp [$];
    longint exp4 [LANES];
    longint exp7 [LANES];

    // reference convolution over all samples since reset
    function automatic longint ref_y(int n, bit seven);
        longint s = 0;
        int nt = seven ? 7 : 4;
        for (int i = 0; i < nt; i++) begin
            if (n - i >= 0)
                s += longint'(seven ? c7[i] : c4[i]) * longint'(smp[n-i]);
        end
        return s;
    endfunction

    task automatic check(string tag, string what, longint got, longint want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, want);
        end
    endtask

    task automatic check_outputs(string tag, bit v);
        check(tag, "valid t4", longint'(out_valid4), longint'(v));
        check(tag, "valid t7", longint'(out_valid7), longint'(v));
        for (int j = 0; j < LANES; j++) begin
            check(tag, $sformatf("t4 lane%0d", j),
                  longint'($signed(out4[j*OW4 +: OW4])), exp4[j]);
            check(tag, $sformatf("t7 lane%0d", j),
                  longint'($signed(out7[j*OW7 +: OW7])), exp7[j]);
        end
    endtask

    // called on a falling edge; returns on the falling edge after the result is due
    task automatic word(string tag, bit v, int d [LANES]);
        in_valid = v;
        for (int j = 0; j < LANES; j++)
            in_data[j*DW +: DW] = DW'(d[j]);
        if (v) begin
            for (int j = 0; j < LANES; j++) begin
                smp.push_back(d[j]);
                exp4[j] = ref_y(smp.size() - 1, 1'b0);
                exp7[j] = ref_y(smp.size() - 1, 1'b1);
            end
        end
        @(posedge clk);
        @(negedge clk);
        check_outputs(tag, v);
    endtask

    task automatic do_reset(string tag);
        rst = 1'b1;
        in_valid = 1'b1;
        in_data = {LANES{12'h5A5}};
        @(posedge clk);
        @(negedge clk);
        smp.delete();
        for (int j = 0; j < LANES; j++) begin
            exp4[j] = 0;
            exp7[j] = 0;
        end
        check_outputs(tag, 1'b0);
        rst = 1'b0;
        in_valid = 1'b0;
    endtask

    function automatic int rnd_s();
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    initial begin
        int z [LANES] = '{0, 0, 0, 0};
        int d [LANES];
        void'($urandom(32'd77123));
        repeat (3) @(posedge clk);
        @(negedge clk);
        do_reset("R6");

        // R2: impulse at lane 0, then its tail through later words (R3)
        word("R2", 1'b1, '{1000, 0, 0, 0});
        repeat (3) word("R3", 1'b1, z);
        // impulse in the newest lane reaches across two words of history
        word("R2", 1'b1, '{0, 0, 0, -777});
        repeat (3) word("R3", 1'b1, z);

        // step response
        repeat (4) word("R2", 1'b1, '{100, 100, 100, 100});

        // R5: idle cycles with junk data, then continuation
        word("R5", 1'b0, '{2047, -2048, 5, 9});
        word("R5", 1'b0, '{-1, -1, -1, -1});
        word("R5", 1'b1, '{-300, 12, 45, -6});
        word("R5", 1'b0, '{1, 2, 3, 4});
        word("R3", 1'b1, '{7, -8, 9, -10});

        // R4: extremes
        repeat (3) word("R4", 1'b1, '{-2048, -2048, -2048, -2048});
        repeat (3) word("R4", 1'b1, '{2047, -2048, 2047, -2048});
        repeat (2) word("R4", 1'b1, '{2047, 2047, 2047, 2047});

        // R6: reset mid-stream, history must not leak
        do_reset("R6");
        word("R6", 1'b1, '{0, 0, 0, 0});
        word("R6", 1'b1, '{1, 0, 0, 0});
        repeat (2) word("R6", 1'b1, z);

        // random stream with random gaps
        for (int k = 0; k < 400; k++) begin
            for (int j = 0; j < LANES; j++) d[j] = rnd_s();
            word("R1", ($urandom_range(0, 9) < 8), d);
        end

        in_valid = 1'b0;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule